// File: doc/BRIEF.md
# Masked GPIO Pad Control Bank

A bank of per-pin 16-bit pad control registers on a plain memory-mapped register bus. The bus has a byte address, a write enable, write data and combinational read data. Each register drives one pad. It holds the output level and output enable, the input enable and pull-up, pull-down and slew selections, and a switch that hands the pad over to a peripheral. A read-only status bit reports the input seen on the pad.

Each register carries its own mask of implemented bits and its own reset value. Bits outside the mask are not stored and read as zero. A register that has none of the control bits (bit 0 and bits 8 to 11) is a fixed pad: the peripheral always drives it. For each pin the block has a pad-side interface (input, output, output enable, pull and slew controls) and a peripheral-side interface (output, output enable, and the synchronized pad input).

A hardware-variant input exchanges bits 14 and 15 between the bus and the stored layout, on both writes and reads.

Top module: `gpio_pad_bank`

## Requirements
- R1: After reset, each register reads its own reset value ANDed with its mask. With the default parameters, pins 0..7 reset to 0x8000, 0x0001, 0x8001, 0xC001, 0xC300, 0x0000, 0x8000 and 0x0001.
- R2: Write data bits outside a register's mask are discarded, and those bits always read as zero.
- R3: A write is stored on the clock edge where we_i is high. Reads are combinational. Bit 10 is read-only, and writing it has no effect.
- R4: Register i sits at byte address BASE_OFS + 4*i. A misaligned address, or one outside the bank, reads 0x0000 and ignores writes.
- R5: With bit 0 (alternate function) clear, pad_out_o follows bit 8 (output value) and pad_oe_o follows bit 9 (output enable).
- R6: With bit 0 set, pad_out_o and pad_oe_o follow periph_out_i and periph_oe_i, and bit 8 has no effect on the pad.
- R7: With bit 0 and bit 11 (input enable) both clear, bit 10 reads 0 whatever the pad input.
- R8: With bit 11 set and bit 9 clear, bit 10 reads pad_in_i through a two-flop synchronizer. A change on the pad shows in the read two clock edges later, not one.
- R9: With bits 9 and 11 both set (and bit 0 clear), bit 10 reads the value of bit 8 and not the pad level.
- R10: With bit 0 set, bit 10 reads the synchronized pad input regardless of bit 11. periph_in_o always carries the synchronized pad input.
- R11: A register without bit 0 and bits 8..11 in its mask (pin 0 by default, mask 0xC000) always routes the peripheral's output and output enable to its pad.
- R12: When variant_i is 1, bus bit 14 maps to stored bit 15 (slew) and bus bit 15 maps to stored bit 14, on both writes and reads.
- R13: pad_pu_o, pad_pd_o and pad_fast_o follow stored bits 12, 13 and 15 (slew: 0 slow, 1 fast).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| variant_i | input | 1 | Exchange bits 14 and 15 on the bus |
| addr_i | input | ADDR_W | Byte address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data (combinational) |
| pad_in_i | input | NUM_PINS | Pad input levels |
| pad_out_o | output | NUM_PINS | Pad output levels |
| pad_oe_o | output | NUM_PINS | Pad output enables |
| pad_pu_o | output | NUM_PINS | Pull-up enables |
| pad_pd_o | output | NUM_PINS | Pull-down enables |
| pad_fast_o | output | NUM_PINS | Fast slew select |
| periph_out_i | input | NUM_PINS | Peripheral output levels |
| periph_oe_i | input | NUM_PINS | Peripheral output enables |
| periph_in_o | output | NUM_PINS | Synchronized pad input to peripheral |

## Verification
The assertions run on every cycle and cover the pad side. They check that stored bits stay inside each mask, that the pad mux chooses the peripheral or the register as bit 0 and the fixed-pad rule require, and that the pull and slew outputs follow their bits. They also check the two-cycle delay of the synchronizer and that unmapped writes change nothing. The read-side behaviour depends on the address, so only the bench scenarios show it: the choice among zero, loopback and synchronized input for bit 10, the bit 14/15 exchange under the variant input, and reset values seen through the bus.

// File: rtl/gpio_pad_pkg.sv
`timescale 1ns/1ps
package gpio_pad_pkg;
  localparam int unsigned REG_W = 16;
  localparam int unsigned BIT_ALT   = 0;
  localparam int unsigned BIT_OUT   = 8;
  localparam int unsigned BIT_OE    = 9;
  localparam int unsigned BIT_IN    = 10;
  localparam int unsigned BIT_IE    = 11;
  localparam int unsigned BIT_PU    = 12;
  localparam int unsigned BIT_PD    = 13;
  localparam int unsigned BIT_SPARE = 14;
  localparam int unsigned BIT_FAST  = 15;
  // bits that make a pad software-controllable
  localparam logic [REG_W-1:0] CTRL_BITS = 16'h0F01;

  function automatic logic [REG_W-1:0] swap_hi(input logic [REG_W-1:0] v, input logic en);
    swap_hi = en ? {v[BIT_SPARE], v[BIT_FAST], v[13:0]} : v;
  endfunction
endpackage

// File: rtl/gpio_addr_dec.sv
`timescale 1ns/1ps
module gpio_addr_dec #(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 8,
  parameter int BASE_OFS = 'h2C
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_PINS-1:0] sel_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [ADDR_W-1:0] rel;
  logic [WORD_W-1:0] word;
  logic              hit;

  always_comb begin
    rel  = addr_i - ADDR_W'(BASE_OFS);
    word = rel[ADDR_W-1:2];
    hit  = (addr_i >= ADDR_W'(BASE_OFS)) && (rel[1:0] == 2'b00) &&
           ({1'b0, word} < (WORD_W+1)'(NUM_PINS));
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_sel
    assign sel_o[i] = hit && (word == WORD_W'(i));
  end
endmodule

// File: rtl/gpio_pad_reg.sv
`timescale 1ns/1ps
module gpio_pad_reg
  import gpio_pad_pkg::*;
#(
  parameter logic [REG_W-1:0] MASK    = 16'hCF01,
  parameter logic [REG_W-1:0] RST_VAL = 16'h0001
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             pad_in_i,
  input  logic             periph_out_i,
  input  logic             periph_oe_i,
  output logic [REG_W-1:0] cfg_o,
  output logic [REG_W-1:0] status_o,
  output logic             pad_out_o,
  output logic             pad_oe_o,
  output logic             pad_pu_o,
  output logic             pad_pd_o,
  output logic             pad_fast_o,
  output logic             periph_in_o
);
  localparam logic [REG_W-1:0] STORE_MASK = MASK & ~(REG_W'(1) << BIT_IN);
  localparam bit               FIXED      = ((MASK & CTRL_BITS) == '0);
  localparam bit               HAS_IN     = MASK[BIT_IN];

  logic [REG_W-1:0] cfg_q;
  logic [1:0]       sync_q;
  logic             pad_sync;
  logic             use_periph;
  logic             in_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= RST_VAL & STORE_MASK;
    else if (wr_i) cfg_q <= wdata_i & STORE_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], pad_in_i};
  end
  assign pad_sync = sync_q[1];

  assign use_periph = FIXED || cfg_q[BIT_ALT];

  always_comb begin
    if (cfg_q[BIT_ALT])     in_bit = pad_sync;
    else if (!cfg_q[BIT_IE]) in_bit = 1'b0;
    else if (cfg_q[BIT_OE]) in_bit = cfg_q[BIT_OUT]; // loopback
    else                    in_bit = pad_sync;
  end

  always_comb begin
    status_o         = cfg_q;
    status_o[BIT_IN] = in_bit & HAS_IN;
  end

  assign cfg_o       = cfg_q;
  assign pad_out_o   = use_periph ? periph_out_i : cfg_q[BIT_OUT];
  assign pad_oe_o    = use_periph ? periph_oe_i  : cfg_q[BIT_OE];
  assign pad_pu_o    = cfg_q[BIT_PU];
  assign pad_pd_o    = cfg_q[BIT_PD];
  assign pad_fast_o  = cfg_q[BIT_FAST];
  assign periph_in_o = pad_sync;
endmodule

// File: rtl/gpio_rd_mux.sv
`timescale 1ns/1ps
module gpio_rd_mux
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic [NUM_PINS-1:0]       sel_i,
  input  logic [NUM_PINS*REG_W-1:0] data_i,
  output logic [REG_W-1:0]          rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      rdata_o |= data_i[i*REG_W +: REG_W] & {REG_W{sel_i[i]}};
    end
  end
endmodule

// File: rtl/gpio_pad_bank.sv
`timescale 1ns/1ps
module gpio_pad_bank
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 8,
  parameter int BASE_OFS = 'h2C,
  parameter logic [NUM_PINS*16-1:0] MASKS = {
    16'hCF01, 16'hFF01, 16'hCF01, 16'hFF01,
    16'hFF01, 16'hCF01, 16'hCF01, 16'hC000},
  parameter logic [NUM_PINS*16-1:0] RST_VALS = {
    16'h0001, 16'h8000, 16'h0000, 16'hC300,
    16'hC001, 16'h8001, 16'h0001, 16'h8000}
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                variant_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [15:0]         wdata_i,
  output logic [15:0]         rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_pu_o,
  output logic [NUM_PINS-1:0] pad_pd_o,
  output logic [NUM_PINS-1:0] pad_fast_o,
  input  logic [NUM_PINS-1:0] periph_out_i,
  input  logic [NUM_PINS-1:0] periph_oe_i,
  output logic [NUM_PINS-1:0] periph_in_o
);
  localparam int BANK_W = NUM_PINS * REG_W;

  logic [NUM_PINS-1:0] sel;
  logic [REG_W-1:0]    wdata_canon;
  logic [REG_W-1:0]    rdata_canon;
  logic [BANK_W-1:0]   cfg_all;
  logic [BANK_W-1:0]   status_all;

  assign wdata_canon = swap_hi(wdata_i, variant_i);

  gpio_addr_dec #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .BASE_OFS(BASE_OFS)
  ) u_dec (
    .addr_i(addr_i),
    .sel_o (sel)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_pad_reg #(
      .MASK   (MASKS[i*REG_W +: REG_W]),
      .RST_VAL(RST_VALS[i*REG_W +: REG_W])
    ) u_reg (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (we_i && sel[i]),
      .wdata_i     (wdata_canon),
      .pad_in_i    (pad_in_i[i]),
      .periph_out_i(periph_out_i[i]),
      .periph_oe_i (periph_oe_i[i]),
      .cfg_o       (cfg_all[i*REG_W +: REG_W]),
      .status_o    (status_all[i*REG_W +: REG_W]),
      .pad_out_o   (pad_out_o[i]),
      .pad_oe_o    (pad_oe_o[i]),
      .pad_pu_o    (pad_pu_o[i]),
      .pad_pd_o    (pad_pd_o[i]),
      .pad_fast_o  (pad_fast_o[i]),
      .periph_in_o (periph_in_o[i])
    );
  end

  gpio_rd_mux #(.NUM_PINS(NUM_PINS)) u_rd (
    .sel_i  (sel),
    .data_i (status_all),
    .rdata_o(rdata_canon)
  );

  assign rdata_o = swap_hi(rdata_canon, variant_i);
endmodule

// File: rtl/gpio_pad_bank_chk.sv
`timescale 1ns/1ps
module gpio_pad_bank_chk #(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 8,
  parameter int BASE_OFS = 'h2C,
  parameter logic [NUM_PINS*16-1:0] MASKS = '0
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [ADDR_W-1:0]      addr_i,
  input logic                   we_i,
  input logic [NUM_PINS-1:0]    pad_in_i,
  input logic [NUM_PINS-1:0]    pad_out_o,
  input logic [NUM_PINS-1:0]    pad_oe_o,
  input logic [NUM_PINS-1:0]    pad_pu_o,
  input logic [NUM_PINS-1:0]    pad_pd_o,
  input logic [NUM_PINS-1:0]    pad_fast_o,
  input logic [NUM_PINS-1:0]    periph_out_i,
  input logic [NUM_PINS-1:0]    periph_oe_i,
  input logic [NUM_PINS-1:0]    periph_in_o,
  input logic [NUM_PINS*16-1:0] cfg_all_i
);
  logic [1:0] cyc_q;
  logic       unmapped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= 2'd0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  assign unmapped = (int'(addr_i) < BASE_OFS) ||
                    (int'(addr_i) >= BASE_OFS + 4*NUM_PINS) ||
                    (addr_i[1:0] != 2'b00);

  a_r4_unmapped_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && unmapped) |=> $stable(cfg_all_i));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    localparam logic [15:0] M = MASKS[i*16 +: 16];
    logic [15:0] c;
    assign c = cfg_all_i[i*16 +: 16];

    a_r2_mask_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (c & ~M) == 16'h0);

    a_r13_pad_attrs: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pad_pu_o[i] == c[12] && pad_pd_o[i] == c[13] && pad_fast_o[i] == c[15]);

    a_r8_sync_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_q >= 2'd2) |-> periph_in_o[i] == $past(pad_in_i[i], 2));

    if ((M & 16'h0F01) == 16'h0) begin : g_fixed
      a_r11_fixed_periph: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pad_out_o[i] == periph_out_i[i] && pad_oe_o[i] == periph_oe_i[i]);
    end else begin : g_ctrl
      a_r6_alt_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
        c[0] |-> (pad_out_o[i] == periph_out_i[i] && pad_oe_o[i] == periph_oe_i[i]));
      a_r5_gpio_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !c[0] |-> (pad_out_o[i] == c[8] && pad_oe_o[i] == c[9]));
    end
  end
endmodule

bind gpio_pad_bank gpio_pad_bank_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .BASE_OFS(BASE_OFS), .MASKS(MASKS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .we_i        (we_i),
  .pad_in_i    (pad_in_i),
  .pad_out_o   (pad_out_o),
  .pad_oe_o    (pad_oe_o),
  .pad_pu_o    (pad_pu_o),
  .pad_pd_o    (pad_pd_o),
  .pad_fast_o  (pad_fast_o),
  .periph_out_i(periph_out_i),
  .periph_oe_i (periph_oe_i),
  .periph_in_o (periph_in_o),
  .cfg_all_i   (cfg_all)
);

// File: tb/gpio_pad_bank_tb.sv
`timescale 1ns/1ps
module gpio_pad_bank_tb;
  localparam int NP = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          variant_i = 1'b0;
  logic [7:0]    addr_i = 8'h00;
  logic          we_i = 1'b0;
  logic [15:0]   wdata_i = 16'h0;
  logic [15:0]   rdata_o;
  logic [NP-1:0] pad_in_i = '0;
  logic [NP-1:0] pad_out_o, pad_oe_o, pad_pu_o, pad_pd_o, pad_fast_o;
  logic [NP-1:0] periph_out_i = '0;
  logic [NP-1:0] periph_oe_i = '0;
  logic [NP-1:0] periph_in_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  gpio_pad_bank u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .variant_i(variant_i),
    .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pad_in_i(pad_in_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o),
    .pad_pu_o(pad_pu_o), .pad_pd_o(pad_pd_o), .pad_fast_o(pad_fast_o),
    .periph_out_i(periph_out_i), .periph_oe_i(periph_oe_i),
    .periph_in_o(periph_in_o)
  );

  function automatic logic [7:0] ra(input int pin);
    ra = 8'(8'h2C + 4*pin);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [15:0] d);
    addr_i = a;
    #0.5;
    d = rdata_o;
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk_i);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    logic [15:0] exp_rst [NP] = '{16'h8000, 16'h0001, 16'h8001, 16'hC001,
                                  16'hC300, 16'h0000, 16'h8000, 16'h0001};
    for (int p = 0; p < NP; p++) begin
      bus_rd(ra(p), v);
      check($sformatf("R1 reset pin%0d", p), v, exp_rst[p]);
    end
    check("R5 reset pad drive pin4", {14'b0, pad_out_o[4], pad_oe_o[4]}, 16'h0003);
  endtask

  task automatic t_mask;
    logic [15:0] v;
    bus_wr(ra(1), 16'hFFFF);
    bus_rd(ra(1), v);
    check("R2 mask CF01 write all ones", v, 16'hCB01);
    bus_wr(ra(0), 16'h7FFF);
    bus_rd(ra(0), v);
    check("R2 mask C000 write", v, 16'h4000);
  endtask

  task automatic t_write_ro;
    logic [15:0] v;
    bus_wr(ra(5), 16'h0400);
    bus_rd(ra(5), v);
    check("R3 bit10 write ignored", v, 16'h0000);
    bus_wr(ra(5), 16'hC000);
    bus_rd(ra(5), v);
    check("R3 write stored", v, 16'hC000);
  endtask

  task automatic t_unmapped;
    logic [15:0] v;
    bus_wr(8'h28, 16'hFFFF);
    bus_wr(8'h2E, 16'hFFFF);
    bus_wr(8'h4C, 16'hFFFF);
    bus_rd(8'h4C, v);
    check("R4 read past bank", v, 16'h0000);
    bus_rd(8'h32, v);
    check("R4 misaligned read", v, 16'h0000);
    bus_rd(ra(5), v);
    check("R4 pin5 untouched", v, 16'hC000);
    bus_rd(ra(7), v);
    check("R4 pin7 untouched", v, 16'h0001);
  endtask

  task automatic t_gpio_drive;
    bus_wr(ra(5), 16'h0300);
    check("R5 out=1 oe=1", {14'b0, pad_out_o[5], pad_oe_o[5]}, 16'h0003);
    bus_wr(ra(5), 16'h0200);
    check("R5 out=0 oe=1", {14'b0, pad_out_o[5], pad_oe_o[5]}, 16'h0001);
    bus_wr(ra(5), 16'h0100);
    check("R5 out=1 oe=0", {14'b0, pad_out_o[5], pad_oe_o[5]}, 16'h0002);
  endtask

  task automatic t_alt;
    bus_wr(ra(7), 16'h0101);
    periph_out_i[7] = 1'b0; periph_oe_i[7] = 1'b1;
    #0.5;
    check("R6 bit8 ignored under alt", {14'b0, pad_out_o[7], pad_oe_o[7]}, 16'h0001);
    periph_out_i[7] = 1'b1; periph_oe_i[7] = 1'b0;
    #0.5;
    check("R6 peripheral drives pad", {14'b0, pad_out_o[7], pad_oe_o[7]}, 16'h0002);
  endtask

  task automatic t_input_paths;
    logic [15:0] v;
    bus_wr(ra(5), 16'h0800);
    pad_in_i[5] = 1'b1;
    wait_cyc(1);
    bus_rd(ra(5), v);
    check("R8 one edge not yet visible", v, 16'h0800);
    wait_cyc(1);
    bus_rd(ra(5), v);
    check("R8 visible after two edges", v, 16'h0C00);
    bus_wr(ra(5), 16'h0000);
    bus_rd(ra(5), v);
    check("R7 input disabled reads zero", v, 16'h0000);
  endtask

  task automatic t_loopback;
    logic [15:0] v;
    pad_in_i[5] = 1'b0;
    bus_wr(ra(5), 16'h0B00);
    wait_cyc(3);
    bus_rd(ra(5), v);
    check("R9 loopback 1 with pad 0", v, 16'h0F00);
    pad_in_i[5] = 1'b1;
    bus_wr(ra(5), 16'h0A00);
    wait_cyc(3);
    bus_rd(ra(5), v);
    check("R9 loopback 0 with pad 1", v, 16'h0A00);
  endtask

  task automatic t_alt_input;
    logic [15:0] v;
    bus_wr(ra(7), 16'h0001);
    pad_in_i[7] = 1'b1;
    wait_cyc(3);
    bus_rd(ra(7), v);
    check("R10 alt input without ie", v, 16'h0401);
    check("R10 periph_in follows pad", {15'b0, periph_in_o[7]}, 16'h0001);
  endtask

  task automatic t_fixed;
    logic [15:0] v;
    bus_wr(ra(0), 16'h0FFF);
    periph_out_i[0] = 1'b1; periph_oe_i[0] = 1'b1;
    pad_in_i[0] = 1'b1;
    wait_cyc(3);
    check("R11 fixed pad peripheral drive", {14'b0, pad_out_o[0], pad_oe_o[0]}, 16'h0003);
    bus_rd(ra(0), v);
    check("R11 fixed pad control bits absent", v, 16'h0000);
    periph_out_i[0] = 1'b0;
    #0.5;
    check("R11 fixed pad follows peripheral", {15'b0, pad_out_o[0]}, 16'h0000);
  endtask

  task automatic t_variant;
    logic [15:0] v;
    bus_wr(ra(6), 16'h8000);
    variant_i = 1'b1;
    bus_rd(ra(6), v);
    check("R12 read swapped", v, 16'h4000);
    bus_wr(ra(6), 16'h8000);
    check("R12 bus bit15 not slew", {15'b0, pad_fast_o[6]}, 16'h0000);
    bus_wr(ra(6), 16'h4000);
    check("R12 bus bit14 is slew", {15'b0, pad_fast_o[6]}, 16'h0001);
    variant_i = 1'b0;
    bus_rd(ra(6), v);
    check("R12 canonical readback", v, 16'h8000);
  endtask

  task automatic t_attrs;
    bus_wr(ra(3), 16'h3000);
    check("R13 pu pd on slow", {13'b0, pad_pu_o[3], pad_pd_o[3], pad_fast_o[3]}, 16'h0006);
    bus_wr(ra(3), 16'h9000);
    check("R13 pu on fast", {13'b0, pad_pu_o[3], pad_pd_o[3], pad_fast_o[3]}, 16'h0005);
  endtask

  initial begin
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(1);
    t_reset();
    t_mask();
    t_write_ro();
    t_unmapped();
    t_gpio_drive();
    t_alt();
    t_input_paths();
    t_loopback();
    t_alt_input();
    t_fixed();
    t_variant();
    t_attrs();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule